// File: doc/BRIEF.md
# Vertical-blanking sideband control capture

This block recovers user-defined control levels that share spare pixel-data inputs with the video stream. During the vertical blanking period, while VSYNC is low and the link runs in its DC-balanced mode, the spare inputs carry control rather than pixels. The block samples them and holds the result, so that a serializer can send the levels in the sideband slots.

A capture window opens on the clock edge that first sees VSYNC low after a high level. Sampling starts on the next edge and repeats on every edge while VSYNC stays low. It stops when VSYNC returns high, and the last captured levels stay frozen until the next window. Cycles with data enable high are never sampled, so active pixels cannot be taken as control. When balance mode is off, nothing is sampled and the inputs remain ordinary data. A valid flag marks each cycle whose output levels came from a fresh sample.

Top module: `vblank_sideband_cap`

## Requirements
- R1: While rst_ni is low, every bit of ctl_o and ctl_vld_o is 0.
- R2: A window opens only at a clock edge where vsync_i is sampled low and was sampled high at the previous edge. The side_i value present at that opening edge is not captured. The first capture happens at the next edge.
- R3: Inside an open window, each clock edge with vsync_i low, de_i low and bal_en_i high captures side_i (bit k into ctl_o bit k). One cycle after the capture edge, ctl_o shows the captured value and ctl_vld_o is 1.
- R4: Once vsync_i is sampled high, the window is closed. From then on ctl_o keeps its last captured value and ctl_vld_o is 0 until a capture in a later window.
- R5: A clock edge with bal_en_i low captures nothing. ctl_o keeps its value and ctl_vld_o is 0 in the following cycle.
- R6: A clock edge with de_i high captures nothing, even inside an open window. ctl_o is held and ctl_vld_o is 0 in the following cycle.
- R7: If vsync_i is low from reset onward and no high level has been sampled, no window is open and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical sync, low during the control window |
| de_i | input | 1 | Data enable, high during active pixels |
| bal_en_i | input | 1 | DC-balanced mode enable |
| side_i | input | NUM_CTL | Spare data inputs carrying sideband control |
| ctl_o | output | NUM_CTL | Held control levels |
| ctl_vld_o | output | 1 | High in the cycle after each fresh capture |

## Verification
Every result appears one cycle after the edge at which its inputs were sampled. The exception is the window opening: it adds one edge, so the first capture becomes visible two cycles after VSYNC is first seen low. The driver sets inputs at the falling clock edge and, for each one, queues the expected ctl_o and ctl_vld_o for the following rising edge. The monitor compares them a quarter period after that rising edge. Hold cases (DE high, balance off, VSYNC high) drive side_i values that differ from the held levels, so a wrongful capture would show at ctl_o.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } vs_edge_t;
endpackage

// File: rtl/vbs_edge_det.sv
module vbs_edge_det
  import vbs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     vsync_i,
  output vs_edge_t edge_o
);
  // reset low: a high level must be seen before any fall counts
  logic vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_q <= 1'b0;
    else         vs_q <= vsync_i;
  end

  always_comb begin
    edge_o.fall = vs_q & ~vsync_i;
    edge_o.rise = ~vs_q & vsync_i;
  end
endmodule

// File: rtl/vbs_window.sv
module vbs_window
  import vbs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  vs_edge_t edge_i,
  input  logic     vsync_i,
  input  logic     de_i,
  input  logic     bal_en_i,
  output logic     smp_o,
  output logic     vld_o
);
  logic win_q;

  // opening edge only arms the window; capture begins on the next edge
  assign smp_o = win_q & ~vsync_i & ~de_i & bal_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      win_q <= edge_i.fall | (win_q & ~edge_i.rise);
      vld_o <= smp_o;
    end
  end
endmodule

// File: rtl/vbs_lane.sv
module vbs_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (smp_i) q_o <= d_i;
  end
endmodule

// File: rtl/vblank_sideband_cap.sv
module vblank_sideband_cap
  import vbs_pkg::*;
#(
  parameter int NUM_CTL = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vsync_i,
  input  logic               de_i,
  input  logic               bal_en_i,
  input  logic [NUM_CTL-1:0] side_i,
  output logic [NUM_CTL-1:0] ctl_o,
  output logic               ctl_vld_o
);
  localparam int LastLane = NUM_CTL - 1;

  vs_edge_t vs_edge;
  logic     smp;

  vbs_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vsync_i (vsync_i),
    .edge_o  (vs_edge)
  );

  vbs_window u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (vs_edge),
    .vsync_i  (vsync_i),
    .de_i     (de_i),
    .bal_en_i (bal_en_i),
    .smp_o    (smp),
    .vld_o    (ctl_vld_o)
  );

  for (genvar k = 0; k <= LastLane; k++) begin : g_lane
    vbs_lane u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp),
      .d_i    (side_i[k]),
      .q_o    (ctl_o[k])
    );
  end
endmodule

// File: rtl/vblank_sideband_cap_chk.sv
module vblank_sideband_cap_chk #(
  parameter int NUM_CTL = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               vsync_i,
  input logic               de_i,
  input logic               bal_en_i,
  input logic [NUM_CTL-1:0] side_i,
  input logic [NUM_CTL-1:0] ctl_o,
  input logic               ctl_vld_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (ctl_o == '0 && !ctl_vld_o);
    end
  end

  p_two_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_vld_o |-> (!$past(vsync_i) && !$past(vsync_i, 2)));

  p_capture_value_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_vld_o |-> ctl_o == $past(side_i));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_vld_o |-> $stable(ctl_o));

  p_bal_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_vld_o |-> $past(bal_en_i));

  p_no_de_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_vld_o |-> !$past(de_i));
endmodule

bind vblank_sideband_cap vblank_sideband_cap_chk #(.NUM_CTL(NUM_CTL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vsync_i   (vsync_i),
  .de_i      (de_i),
  .bal_en_i  (bal_en_i),
  .side_i    (side_i),
  .ctl_o     (ctl_o),
  .ctl_vld_o (ctl_vld_o)
);

// File: tb/vblank_sideband_cap_test.sv
module vblank_sideband_cap_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CTL = 2;

  typedef struct {
    logic [NUM_CTL-1:0] ctl;
    logic               vld;
    string              req;
  } exp_t;

  logic clk = 0;
  logic rst_ni = 0;
  logic vsync = 0, de = 0, bal = 1;
  logic [NUM_CTL-1:0] side = '0;
  logic [NUM_CTL-1:0] ctl;
  logic ctl_vld;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  exp_t q[$];

  // reference state
  logic m_vs_prev = 0, m_win = 0;
  logic [NUM_CTL-1:0] m_ctl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vblank_sideband_cap #(.NUM_CTL(NUM_CTL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .vsync_i(vsync), .de_i(de),
    .bal_en_i(bal), .side_i(side), .ctl_o(ctl), .ctl_vld_o(ctl_vld)
  );

  task automatic step(input logic vs, input logic d, input logic b,
                      input logic [NUM_CTL-1:0] s, input string req);
    exp_t e;
    logic smp, fall;
    @(negedge clk);
    vsync = vs; de = d; bal = b; side = s;
    smp  = b & m_win & ~vs & ~d;
    fall = m_vs_prev & ~vs;
    if (smp) m_ctl = s;
    m_win = fall | (m_win & ~vs);
    m_vs_prev = vs;
    e.ctl = m_ctl; e.vld = smp; e.req = req;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (ctl !== e.ctl || ctl_vld !== e.vld) begin
        n_bad++;
        $display("FAIL %s: ctl=%b vld=%b expected ctl=%b vld=%b",
                 e.req, ctl, ctl_vld, e.ctl, e.vld);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    vsync = 0; side = 2'b11;
    repeat (2) @(negedge clk);
    // R1 reset state
    n_cmp++;
    if (ctl !== '0 || ctl_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: ctl=%b vld=%b expected ctl=00 vld=0", ctl, ctl_vld);
    end
    rst_ni = 1;
    // R7: low from reset, no window
    for (int i = 0; i < 4; i++) step(0, 0, 1, 2'b11, "R7");
    // R2: high then fall; fall-cycle value not captured
    step(1, 0, 1, 2'b11, "R2");
    step(1, 0, 1, 2'b11, "R2");
    step(0, 0, 1, 2'b11, "R2");
    step(0, 0, 1, 2'b10, "R2");
    // R3: continuous re-sampling
    step(0, 0, 1, 2'b01, "R3");
    step(0, 0, 1, 2'b11, "R3");
    step(0, 0, 1, 2'b00, "R3");
    // R6: de high suppresses
    step(0, 1, 1, 2'b11, "R6");
    step(0, 1, 1, 2'b10, "R6");
    step(0, 0, 1, 2'b01, "R6");
    // R5: balance mode off
    step(0, 0, 0, 2'b10, "R5");
    step(0, 0, 0, 2'b11, "R5");
    // R4: vsync high holds
    step(1, 0, 1, 2'b10, "R4");
    step(1, 0, 1, 2'b00, "R4");
    step(1, 0, 1, 2'b11, "R4");
    // R2 new window after rise
    step(0, 0, 1, 2'b00, "R2");
    step(0, 0, 1, 2'b10, "R2");
    step(0, 1, 1, 2'b01, "R6");
    step(1, 0, 1, 2'b01, "R4");
    step(1, 0, 1, 2'b11, "R4");
    // R5: window stays open across bal gap
    step(0, 0, 0, 2'b11, "R5");
    step(0, 0, 0, 2'b00, "R5");
    step(0, 0, 1, 2'b11, "R3");
    step(0, 0, 1, 2'b01, "R3");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule